// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block watches the pump-up and pump-down pulses of a phase-frequency detector and drives an active-high lock flag. A fast sample clock measures the phase error of each comparison cycle: the number of sample ticks in that cycle during which at least one of the two pump pulses is high. A one-tick strobe marks the last tick of every comparison cycle, and the finished measurement is judged on that tick.

While unlocked, the block counts good cycles in a row, where good means an error below a tight limit. When the run reaches the length chosen by a mode pin, lock is declared. Once locked, only a cycle whose error exceeds a looser limit clears the flag. Errors between the two limits leave an established lock alone, so the two limits give hysteresis. The limits and both run lengths are parameters. With a 1 GHz sample clock, the defaults of 15 and 25 ticks correspond to 15 ns and 25 ns.

All pins are plain control and status signals. No data stream passes through the block, so there is no handshake.

Top module: `pll_lock_monitor`

## Requirements
- R1: The lock output `locked` is active high and is 0 after reset.
- R2: With `run_sel` = 0, `locked` rises on the strobe edge that ends the third consecutive cycle whose error is below LOCK_LIM (15). It is still 0 after only two such cycles.
- R3: With `run_sel` = 1, five consecutive cycles whose error is below LOCK_LIM are required. Four are not enough.
- R4: While locked, a cycle whose error is at or above LOCK_LIM but at most UNLOCK_LIM (25) leaves `locked` at 1.
- R5: While locked, a single cycle whose error is greater than UNLOCK_LIM clears `locked` on that cycle's strobe edge.
- R6: Synchronous reset `rst` (active high) clears the lock flag and the run counter. Reset wins over a strobe in the same cycle.
- R7: While unlocked, a cycle whose error is at or above LOCK_LIM (a 15-tick error counts as bad, a 14-tick error as good) sets the run count back to zero.
- R8: The error is the number of ticks, up to and including the strobe tick, in which `pump_up` or `pump_dn` is high. A tick where both are high counts once.
- R9: A change of `run_sel` while unlocked applies from the next strobe. The run already counted is kept and compared against the new length.
- R10: The error accumulator saturates above UNLOCK_LIM and never wraps. A very long pulse therefore counts as a bad cycle: it never locks, and it unlocks.
- R11: `locked` changes only on a clock edge where `cycle_end` is high or `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| pump_up | input | 1 | Pump-up pulse from the phase detector |
| pump_dn | input | 1 | Pump-down pulse from the phase detector |
| run_sel | input | 1 | Run length select: 0 for the short run, 1 for the long run |
| cycle_end | input | 1 | High on the last tick of each comparison cycle |
| locked | output | 1 | Lock flag, active high |

## Verification
Two things can fall in the same sample tick. The first is the cycle-end strobe together with a tick that has a pump pulse active. The bench keeps a pump pulse high through the strobe tick of a 26-tick cycle while locked. That tick must bring the count to 26 and unlock, whereas dropping it would leave 25 and hold lock. The second is reset arriving together with a strobe that would complete a run. The bench expects reset to win, with lock still 0 and a fresh run needed afterwards.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;
  typedef enum logic {
    SEEK = 1'b0,
    HELD = 1'b1
  } lock_state_e;
endpackage

// File: rtl/pll_err_meter.sv
module pll_err_meter #(
  parameter int CAP   = 26,
  parameter int ERR_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pump_up,
  input  logic             pump_dn,
  input  logic             cycle_end,
  output logic [ERR_W-1:0] meas_err
);
  localparam logic [ERR_W-1:0] CAP_V = ERR_W'(CAP);

  logic [ERR_W-1:0] acc_q;
  logic             active;

  assign active = pump_up | pump_dn;

  // Running total including the current tick, held at CAP so it never wraps
  always_comb begin
    if (acc_q >= CAP_V)  meas_err = CAP_V;
    else if (active)     meas_err = acc_q + ERR_W'(1);
    else                 meas_err = acc_q;
  end

  always_ff @(posedge clk) begin
    if (rst)            acc_q <= '0;
    else if (cycle_end) acc_q <= '0;
    else                acc_q <= meas_err;
  end
endmodule

// File: rtl/pll_run_judge.sv
module pll_run_judge
  import pll_lock_pkg::*;
#(
  parameter int LOCK_LIM   = 15,
  parameter int UNLOCK_LIM = 25,
  parameter int RUN_SHORT  = 3,
  parameter int RUN_LONG   = 5,
  parameter int ERR_W      = 5,
  parameter int CNT_W      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic             run_sel,
  input  logic [ERR_W-1:0] meas_err,
  output logic             locked,
  output logic [CNT_W-1:0] good_cnt
);
  localparam logic [ERR_W-1:0] LOCK_T   = ERR_W'(LOCK_LIM);
  localparam logic [ERR_W-1:0] UNLOCK_T = ERR_W'(UNLOCK_LIM);
  localparam logic [CNT_W-1:0] SHORT_N  = CNT_W'(RUN_SHORT);
  localparam logic [CNT_W-1:0] LONG_N   = CNT_W'(RUN_LONG);

  lock_state_e      state_q;
  logic [CNT_W-1:0] need;
  logic [CNT_W-1:0] next_cnt;
  logic             is_good;
  logic             is_bad;

  assign need     = run_sel ? LONG_N : SHORT_N;
  assign is_good  = meas_err < LOCK_T;
  assign is_bad   = meas_err > UNLOCK_T;
  assign next_cnt = (good_cnt >= need) ? need : good_cnt + CNT_W'(1);
  assign locked   = (state_q == HELD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SEEK;
      good_cnt <= '0;
    end else if (strobe) begin
      if (state_q == HELD) begin
        if (is_bad) begin
          state_q  <= SEEK;
          good_cnt <= '0;
        end
      end else if (is_good) begin
        good_cnt <= next_cnt;
        if (next_cnt >= need) state_q <= HELD;
      end else begin
        good_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
  parameter int LOCK_LIM   = 15,
  parameter int UNLOCK_LIM = 25,
  parameter int RUN_SHORT  = 3,
  parameter int RUN_LONG   = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic pump_up,
  input  logic pump_dn,
  input  logic run_sel,
  input  logic cycle_end,
  output logic locked
);
  localparam int ERR_CAP = UNLOCK_LIM + 1;
  localparam int ERR_W   = $clog2(ERR_CAP + 1);
  localparam int CNT_W   = $clog2(RUN_LONG + 1);

  logic [ERR_W-1:0] meas_err;
  logic [CNT_W-1:0] good_cnt;

  pll_err_meter #(
    .CAP  (ERR_CAP),
    .ERR_W(ERR_W)
  ) u_meter (
    .clk      (clk),
    .rst      (rst),
    .pump_up  (pump_up),
    .pump_dn  (pump_dn),
    .cycle_end(cycle_end),
    .meas_err (meas_err)
  );

  pll_run_judge #(
    .LOCK_LIM  (LOCK_LIM),
    .UNLOCK_LIM(UNLOCK_LIM),
    .RUN_SHORT (RUN_SHORT),
    .RUN_LONG  (RUN_LONG),
    .ERR_W     (ERR_W),
    .CNT_W     (CNT_W)
  ) u_judge (
    .clk     (clk),
    .rst     (rst),
    .strobe  (cycle_end),
    .run_sel (run_sel),
    .meas_err(meas_err),
    .locked  (locked),
    .good_cnt(good_cnt)
  );
endmodule

// File: rtl/pll_lock_monitor_chk.sv
module pll_lock_monitor_chk #(
  parameter int LOCK_LIM   = 15,
  parameter int UNLOCK_LIM = 25,
  parameter int RUN_LONG   = 5,
  parameter int ERR_W      = 5,
  parameter int CNT_W      = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cycle_end,
  input logic             locked,
  input logic [ERR_W-1:0] meas_err,
  input logic [CNT_W-1:0] good_cnt
);
  // R6
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!locked && good_cnt == '0));

  // R5
  drop_on_bad_chk: assert property (@(posedge clk) disable iff (rst)
    (cycle_end && locked && meas_err > ERR_W'(UNLOCK_LIM)) |=> !locked);

  // R4
  hold_band_chk: assert property (@(posedge clk) disable iff (rst)
    (cycle_end && locked && meas_err <= ERR_W'(UNLOCK_LIM)) |=> locked);

  // R7
  run_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (cycle_end && !locked && meas_err >= ERR_W'(LOCK_LIM)) |=> (good_cnt == '0 && !locked));

  // R11
  quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cycle_end |=> $stable(locked));

  // R10
  run_cap_chk: assert property (@(posedge clk) disable iff (rst)
    good_cnt <= CNT_W'(RUN_LONG));

  // R10
  err_cap_chk: assert property (@(posedge clk) disable iff (rst)
    meas_err <= ERR_W'(UNLOCK_LIM + 1));
endmodule

bind pll_lock_monitor pll_lock_monitor_chk #(
  .LOCK_LIM  (LOCK_LIM),
  .UNLOCK_LIM(UNLOCK_LIM),
  .RUN_LONG  (RUN_LONG),
  .ERR_W     (ERR_W),
  .CNT_W     (CNT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cycle_end(cycle_end),
  .locked   (locked),
  .meas_err (meas_err),
  .good_cnt (good_cnt)
);

// File: tb/pll_lock_monitor_tb.sv
module pll_lock_monitor_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pump_up = 1'b0;
  logic pump_dn = 1'b0;
  logic run_sel = 1'b0;
  logic cycle_end = 1'b0;
  logic locked;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pll_lock_monitor u_dut (
    .clk(clk), .rst(rst), .pump_up(pump_up), .pump_dn(pump_dn),
    .run_sel(run_sel), .cycle_end(cycle_end), .locked(locked)
  );

  task automatic check(input logic exp, input string req);
    total++;
    if (locked !== exp) begin
      bad++;
      $display("FAIL %s: locked=%b expected=%b", req, locked, exp);
    end
  endtask

  // One comparison cycle of len ticks; up high on ticks [0,up_n), down on [dn_a,dn_b)
  task automatic cyc(input int up_n, input int dn_a, input int dn_b, input int len);
    for (int t = 0; t < len; t++) begin
      @(negedge clk);
      pump_up   = (t < up_n);
      pump_dn   = (t >= dn_a) && (t < dn_b);
      cycle_end = (t == len - 1);
    end
    @(negedge clk);
    pump_up = 1'b0; pump_dn = 1'b0; cycle_end = 1'b0;
  endtask

  task automatic good_cyc();
    cyc(10, 0, 0, 40);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check(1'b0, "R1");
  endtask

  task automatic t_short_run();
    do_reset(); run_sel = 1'b0;
    good_cyc(); good_cyc();
    check(1'b0, "R2");
    good_cyc();
    check(1'b1, "R2");
  endtask

  task automatic t_hysteresis();
    cyc(20, 0, 0, 40);
    check(1'b1, "R4");
    cyc(25, 0, 0, 40);
    check(1'b1, "R4");
    cyc(26, 0, 0, 40);
    check(1'b0, "R5");
  endtask

  task automatic t_long_run();
    do_reset(); run_sel = 1'b1;
    for (int i = 0; i < 4; i++) good_cyc();
    check(1'b0, "R3");
    good_cyc();
    check(1'b1, "R3");
  endtask

  task automatic t_reset_vs_strobe();
    do_reset(); run_sel = 1'b0;
    good_cyc(); good_cyc();
    // third good cycle, reset raised on its strobe tick
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      pump_up = (t < 10);
      cycle_end = (t == 39);
      rst = (t == 39);
    end
    @(negedge clk); cycle_end = 1'b0; rst = 1'b0;
    check(1'b0, "R6");
    good_cyc(); good_cyc();
    check(1'b0, "R6");
    good_cyc();
    check(1'b1, "R6");
  endtask

  task automatic t_restart();
    do_reset(); run_sel = 1'b0;
    good_cyc(); good_cyc();
    cyc(15, 0, 0, 40);
    good_cyc(); good_cyc();
    check(1'b0, "R7");
    cyc(14, 0, 0, 40);
    check(1'b1, "R7");
  endtask

  task automatic t_union();
    do_reset(); run_sel = 1'b0;
    // both pumps high on the same 12 ticks: counts 12, good
    for (int i = 0; i < 3; i++) cyc(12, 0, 12, 40);
    check(1'b1, "R8");
    // up 0..13, down 13..26: union 27 ticks, unlocks
    cyc(14, 13, 27, 40);
    check(1'b0, "R8");
  endtask

  task automatic t_end_tick();
    do_reset(); run_sel = 1'b0;
    good_cyc(); good_cyc(); good_cyc();
    cyc(0, 0, 25, 25);
    check(1'b1, "R8");
    cyc(0, 0, 26, 26);
    check(1'b0, "R8");
  endtask

  task automatic t_mode_change();
    do_reset(); run_sel = 1'b1;
    good_cyc(); good_cyc(); good_cyc();
    check(1'b0, "R9");
    run_sel = 1'b0;
    good_cyc();
    check(1'b1, "R9");
    do_reset(); run_sel = 1'b0;
    good_cyc(); good_cyc();
    run_sel = 1'b1;
    good_cyc();
    check(1'b0, "R9");
    good_cyc(); good_cyc();
    check(1'b1, "R9");
  endtask

  task automatic t_saturate();
    do_reset(); run_sel = 1'b0;
    for (int i = 0; i < 3; i++) cyc(300, 0, 0, 310);
    check(1'b0, "R10");
    good_cyc(); good_cyc(); good_cyc();
    cyc(300, 0, 0, 310);
    check(1'b0, "R10");
  endtask

  task automatic t_no_strobe();
    do_reset(); run_sel = 1'b0;
    good_cyc(); good_cyc(); good_cyc();
    for (int t = 0; t < 60; t++) begin
      @(negedge clk); pump_up = 1'b1;
    end
    @(negedge clk); pump_up = 1'b0;
    check(1'b1, "R11");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_short_run();
        t_hysteresis();
        t_long_run();
        t_reset_vs_strobe();
        t_restart();
        t_union();
        t_end_tick();
        t_mode_change();
        t_saturate();
        t_no_strobe();
        done = 1'b1;
      end
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog: run did not finish, expected completion");
        end
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule